// File: doc/BRIEF.md
# Byte-Wide Strobed Register Bus Master

This block is the host end of a narrow register bus. One 8-bit path carries both the register address and the data bytes. A direction line says which side drives the path. An address strobe marks an address byte and a data strobe marks a data byte. The peripheral on the far side holds up to 256 registers.

The controller takes one command at a time on a valid/ready port. A command is an operation, an address and a byte count. It then runs the whole bus sequence on its own:

- It drives the bus and times the strobes.
- It turns the direction around for reads.
- It pulls write bytes from an input stream.
- It pushes read bytes to an output stream.

Two extra operations put the peripheral into raw mode and bring it back out. In raw mode the bus is not interpreted.

All timing is counted in clocks of the block's own clock, and each interval is a parameter with a minimum of one:

- `T_SETUP`: how long a byte sits on the bus before its strobe rises.
- `T_HIGH`: how long a strobe stays high.
- `T_LOW`: how long a strobe stays low before the next strobe or before the command ends.
- `T_TURN`: how long the bus settles after the direction flips to peripheral-drives.

Top module: `bytebus_master`

## Requirements
- R1: Out of reset, `bus_oe`, `bus_dir`, `bus_astb`, `bus_dstb`, `busy`, `raw_active`, `rd_valid` and `wr_ready` are all 0, and `cmd_ready` is 1.
- R2: Every address phase holds `bus_dir`=0 and `bus_oe`=1. The address byte is on `bus_dout` for at least `T_SETUP` clocks before `bus_astb` rises. `bus_astb` then stays high exactly `T_HIGH` clocks. It then stays low at least `T_LOW` clocks before any further strobe.
- R3: Operation code 0 (select) with a nonzero address produces one address strobe carrying that address and no data strobe.
- R4: Operation code 1 (write) with count N≥1 and a nonzero address runs an address phase and then N data strobes. Each data strobe carries the next byte taken from the write stream, with `bus_dir`=0. Each byte meets `T_SETUP` before its strobe, and each data strobe is high exactly `T_HIGH` clocks.
- R5: Operation code 2 (read) with count N≥1 and a nonzero address works as follows:
  - After the address phase, `bus_dir` goes to 1 and `bus_oe` to 0 for `T_TURN` clocks.
  - The master then samples `bus_din` and offers the byte on the read stream.
  - Only after that byte is accepted does it pulse `bus_dstb`. The byte that appears after each strobe's `T_LOW` settle is sampled next.
  - The command delivers N bytes with N data strobes.
- R6: `bus_oe` is 0 whenever `bus_dir` is 1. `bus_dir` falls back to 0 only when `bus_oe` was already 0 on the previous clock. After a read ends, both are 0.
- R7: A write or read with count 0 and a nonzero address performs only the address phase. It touches neither stream.
- R8: A command with address 0x00 enters raw mode, whatever its operation and count. So does operation code 3 (raw enter), whatever its address. Either way the master issues one address strobe carrying 0x00 and no data phase, touches neither stream, and sets `raw_active` to 1.
- R9: While `raw_active` is 1:
  - Operation code 4 (raw exit) issues one address strobe and clears `raw_active`.
  - Every other command is accepted and dropped with no strobe, `busy` staying 0.
- R10: Operation code 4 while `raw_active` is 0 is accepted and dropped with no strobe and no change of state.
- R11: `cmd_ready` is 1 only while the master is idle. An accepted command that moves the bus raises `busy` on the next clock. `busy` stays high until the sequence ends. No strobe is ever high while `busy` is 0.
- R12: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this clock (idle only) |
| cmd_op | input | 3 | 0 select, 1 write, 2 read, 3 raw enter, 4 raw exit |
| cmd_addr | input | 8 | Register address |
| cmd_len | input | LEN_W | Byte count for write or read |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| bus_din | input | 8 | Bus value driven by the peripheral |
| bus_dout | output | 8 | Bus value driven by the master |
| bus_oe | output | 1 | Master drives the bus |
| bus_dir | output | 1 | 0 master drives, 1 peripheral drives |
| bus_astb | output | 1 | Address strobe |
| bus_dstb | output | 1 | Data strobe |
| busy | output | 1 | A bus sequence is in progress |
| raw_active | output | 1 | Peripheral is in raw mode |

## Verification
The bound checker watches every clock for these properties:
- the output enable and the direction never both being high;
- the direction only falling after the enable has been released for a clock;
- the two strobes being mutually exclusive and of exact high width;
- strobes only appearing while busy;
- data strobes being absent in raw mode;
- held read bytes staying put under backpressure.

The directed scenarios are the only way to show the rest: that the right bytes travel in the right order, that burst counts are exact, that setup and low gaps are long enough, and that raw-mode commands are dropped or turned into exit pulses. To do so they compare the strobes seen on the bus and the stream handshakes with patterns the bench computes itself.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  localparam logic [2:0] OP_SELECT    = 3'd0;
  localparam logic [2:0] OP_WRITE     = 3'd1;
  localparam logic [2:0] OP_READ      = 3'd2;
  localparam logic [2:0] OP_RAW_ENTER = 3'd3;
  localparam logic [2:0] OP_RAW_EXIT  = 3'd4;

  localparam logic [7:0] RAW_ADDR = 8'h00;

  typedef enum logic [2:0] {
    ACT_DROP,
    ACT_SELECT,
    ACT_WRITE,
    ACT_READ,
    ACT_ENTER,
    ACT_EXIT
  } act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ASETUP,
    ST_AHIGH,
    ST_ALOW,
    ST_WGET,
    ST_WSETUP,
    ST_TURN,
    ST_RPUSH,
    ST_DHIGH,
    ST_DLOW,
    ST_REL
  } st_e;

  // Map a request onto the bus action it really causes, given raw mode.
  function automatic act_e decode_cmd(input logic [2:0] op, input logic [7:0] addr,
                                      input logic raw, input logic len_zero);
    act_e a;
    a = ACT_DROP;
    if (raw) begin
      if (op == OP_RAW_EXIT) a = ACT_EXIT;
    end else begin
      case (op)
        OP_SELECT:    a = (addr == RAW_ADDR) ? ACT_ENTER : ACT_SELECT;
        OP_WRITE:     a = (addr == RAW_ADDR) ? ACT_ENTER :
                          (len_zero ? ACT_SELECT : ACT_WRITE);
        OP_READ:      a = (addr == RAW_ADDR) ? ACT_ENTER :
                          (len_zero ? ACT_SELECT : ACT_READ);
        OP_RAW_ENTER: a = ACT_ENTER;
        default:      a = ACT_DROP;
      endcase
    end
    return a;
  endfunction

  // Number of clocks a state lasts; untimed states report 1.
  function automatic int unsigned phase_limit(input st_e st, input int unsigned ts,
                                              input int unsigned th, input int unsigned tl,
                                              input int unsigned tt);
    int unsigned r;
    case (st)
      ST_ASETUP, ST_WSETUP: r = ts;
      ST_AHIGH, ST_DHIGH:   r = th;
      ST_ALOW, ST_DLOW:     r = tl;
      ST_TURN:              r = tt;
      default:              r = 1;
    endcase
    return r;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bbm_phase_timer.sv
module bbm_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bbm_burst_count.sv
module bbm_burst_count #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [LEN_W-1:0] rem_q;

  assign last = (rem_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      rem_q <= '0;
    else if (load)                   rem_q <= load_val;
    else if (dec && rem_q != '0)     rem_q <= rem_q - 1'b1;
  end

endmodule

// File: rtl/bbm_sequencer.sv
module bbm_sequencer
  import bbm_pkg::*;
#(
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_HIGH  = 1,
  parameter int unsigned T_LOW   = 1,
  parameter int unsigned T_TURN  = 1,
  parameter int unsigned CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [7:0]    cmd_addr,
  input  logic          cmd_len_zero,
  output logic          burst_load,
  output logic          burst_dec,
  input  logic          burst_last,
  output logic          t_restart,
  output logic [CW-1:0] t_limit,
  input  logic          t_done,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  input  logic [7:0]    bus_din,
  output logic [7:0]    bus_dout,
  output logic          bus_oe,
  output logic          bus_dir,
  output logic          bus_astb,
  output logic          bus_dstb,
  output logic          busy,
  output logic          raw_active,
  output logic          ev_sample
);

  st_e        st_q, st_n;
  act_e       act_q, act_in;
  logic [7:0] addr_q, data_q;
  logic       raw_q;
  logic       accept, go, is_read, wr_take, addr_done;

  assign act_in    = decode_cmd(cmd_op, cmd_addr, raw_q, cmd_len_zero);
  assign accept    = (st_q == ST_IDLE) && cmd_valid;
  assign go        = accept && (act_in != ACT_DROP);
  assign is_read   = (act_q == ACT_READ);
  assign wr_take   = (st_q == ST_WGET) && wr_valid;
  assign addr_done = (st_q == ST_ALOW) && t_done;

  assign ev_sample  = t_done && ((st_q == ST_TURN) ||
                      ((st_q == ST_DLOW) && is_read && !burst_last));
  assign burst_load = go;
  assign burst_dec  = (st_q == ST_DLOW) && t_done;
  assign t_restart  = (st_n != st_q);
  assign t_limit    = CW'(phase_limit(st_q, T_SETUP, T_HIGH, T_LOW, T_TURN));

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:   if (go) st_n = ST_ASETUP;
      ST_ASETUP: if (t_done) st_n = ST_AHIGH;
      ST_AHIGH:  if (t_done) st_n = ST_ALOW;
      ST_ALOW:
        if (t_done) begin
          if (act_q == ACT_WRITE)     st_n = ST_WGET;
          else if (act_q == ACT_READ) st_n = ST_TURN;
          else                        st_n = ST_IDLE;
        end
      ST_WGET:   if (wr_valid) st_n = ST_WSETUP;
      ST_WSETUP: if (t_done) st_n = ST_DHIGH;
      ST_TURN:   if (t_done) st_n = ST_RPUSH;
      ST_RPUSH:  if (rd_ready) st_n = ST_DHIGH;
      ST_DHIGH:  if (t_done) st_n = ST_DLOW;
      ST_DLOW:
        if (t_done) begin
          if (burst_last) st_n = is_read ? ST_REL : ST_IDLE;
          else            st_n = is_read ? ST_RPUSH : ST_WGET;
        end
      ST_REL:    st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_q  <= ACT_DROP;
      addr_q <= '0;
      data_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (go) begin
        act_q  <= act_in;
        addr_q <= (act_in == ACT_ENTER) ? RAW_ADDR : cmd_addr;
      end
      if (wr_take)   data_q <= wr_data;
      if (ev_sample) data_q <= bus_din;
      if (addr_done) begin
        if (act_q == ACT_ENTER)     raw_q <= 1'b1;
        else if (act_q == ACT_EXIT) raw_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_oe  = 1'b0;
    bus_dir = 1'b0;
    case (st_q)
      ST_ASETUP, ST_AHIGH, ST_ALOW, ST_WGET, ST_WSETUP: bus_oe = 1'b1;
      ST_TURN, ST_RPUSH, ST_REL:                         bus_dir = 1'b1;
      ST_DHIGH, ST_DLOW: begin
        bus_dir = is_read;
        bus_oe  = !is_read;
      end
      default: ;
    endcase
  end

  assign bus_dout   = (st_q == ST_ASETUP || st_q == ST_AHIGH || st_q == ST_ALOW) ?
                      addr_q : data_q;
  assign bus_astb   = (st_q == ST_AHIGH);
  assign bus_dstb   = (st_q == ST_DHIGH);
  assign busy       = (st_q != ST_IDLE);
  assign cmd_ready  = (st_q == ST_IDLE);
  assign wr_ready   = (st_q == ST_WGET);
  assign rd_valid   = (st_q == ST_RPUSH);
  assign rd_data    = data_q;
  assign raw_active = raw_q;

endmodule

// File: rtl/bytebus_master.sv
module bytebus_master
  import bbm_pkg::*;
#(
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_HIGH  = 2,
  parameter int unsigned T_LOW   = 2,
  parameter int unsigned T_TURN  = 1,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  input  logic [7:0]       bus_din,
  output logic [7:0]       bus_dout,
  output logic             bus_oe,
  output logic             bus_dir,
  output logic             bus_astb,
  output logic             bus_dstb,
  output logic             busy,
  output logic             raw_active
);

  localparam int unsigned TMAX = max4(T_SETUP, T_HIGH, T_LOW, T_TURN);
  localparam int unsigned CW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  logic          burst_load, burst_dec, burst_last;
  logic          t_restart, t_done;
  logic [CW-1:0] t_limit;
  logic          ev_sample;

  bbm_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (t_restart),
    .limit   (t_limit),
    .done    (t_done)
  );

  bbm_burst_count #(.LEN_W(LEN_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (burst_load),
    .load_val (cmd_len),
    .dec      (burst_dec),
    .last     (burst_last)
  );

  bbm_sequencer #(
    .T_SETUP (T_SETUP),
    .T_HIGH  (T_HIGH),
    .T_LOW   (T_LOW),
    .T_TURN  (T_TURN),
    .CW      (CW)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_len_zero (cmd_len == '0),
    .burst_load   (burst_load),
    .burst_dec    (burst_dec),
    .burst_last   (burst_last),
    .t_restart    (t_restart),
    .t_limit      (t_limit),
    .t_done       (t_done),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .bus_din      (bus_din),
    .bus_dout     (bus_dout),
    .bus_oe       (bus_oe),
    .bus_dir      (bus_dir),
    .bus_astb     (bus_astb),
    .bus_dstb     (bus_dstb),
    .busy         (busy),
    .raw_active   (raw_active),
    .ev_sample    (ev_sample)
  );

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
  parameter int unsigned T_HIGH = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_oe,
  input logic       bus_dir,
  input logic       bus_astb,
  input logic       bus_dstb,
  input logic       busy,
  input logic       cmd_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       raw_active,
  input logic       ev_sample
);

  logic [15:0] ahi_q, dhi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ahi_q <= '0;
      dhi_q <= '0;
    end else begin
      ahi_q <= bus_astb ? ahi_q + 1'b1 : '0;
      dhi_q <= bus_dstb ? dhi_q + 1'b1 : '0;
    end
  end

  p_oe_dir_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && bus_dir));

  p_dir_fall_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_dir) |-> (!bus_oe && !$past(bus_oe)));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_astb && bus_dstb));

  p_astb_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_astb |-> (bus_oe && !bus_dir));

  p_astb_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_astb) |-> (ahi_q == 16'(T_HIGH)));

  p_dstb_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_dstb) |-> (dhi_q == 16'(T_HIGH)));

  p_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_astb || bus_dstb) |-> busy);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_raw_no_dstb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    raw_active |-> !bus_dstb);

  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> (bus_dir && !bus_oe));

endmodule

bind bytebus_master bbm_checker #(.T_HIGH(T_HIGH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_oe     (bus_oe),
  .bus_dir    (bus_dir),
  .bus_astb   (bus_astb),
  .bus_dstb   (bus_dstb),
  .busy       (busy),
  .cmd_ready  (cmd_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .raw_active (raw_active),
  .ev_sample  (ev_sample)
);

// File: tb/bytebus_master_tb.sv
`timescale 1ns/1ps
module bytebus_master_tb;

  localparam int unsigned T_SETUP = 2;
  localparam int unsigned T_HIGH  = 3;
  localparam int unsigned T_LOW   = 2;
  localparam int unsigned T_TURN  = 2;
  localparam int unsigned LEN_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_addr = 8'h00;
  logic [LEN_W-1:0] cmd_len = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data;
  logic rd_valid;
  logic rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic [7:0] bus_din;
  logic [7:0] bus_dout;
  logic bus_oe, bus_dir, bus_astb, bus_dstb, busy, raw_active;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bytebus_master #(
    .T_SETUP(T_SETUP), .T_HIGH(T_HIGH), .T_LOW(T_LOW), .T_TURN(T_TURN), .LEN_W(LEN_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_dir(bus_dir),
    .bus_astb(bus_astb), .bus_dstb(bus_dstb), .busy(busy), .raw_active(raw_active)
  );

  function automatic logic [7:0] wpat(input int i);
    return 8'hC3 ^ 8'(i * 29);
  endfunction

  function automatic logic [7:0] rpat(input int i);
    return 8'hA0 ^ 8'(i * 19 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Streams and peripheral model
  int wr_idx = 0;
  int rx_n = 0;
  int rd_idx = 0;
  logic [7:0] rx_log [64];
  bit stall = 1'b0;
  int cyc = 0;

  assign wr_data = wpat(wr_idx);
  assign bus_din = rpat(rd_idx);

  always @(posedge clk) begin
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
    if (rd_valid && rd_ready) begin
      rx_log[rx_n % 64] <= rd_data;
      rx_n <= rx_n + 1;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  // Bus monitor
  int astb_cnt = 0, dstb_cnt = 0;
  logic [7:0] a_log [64];
  logic [7:0] d_log [64];
  int a_hi = 0, d_hi = 0, low_run = 0, stab = 0;
  bit had_fall = 1'b0;
  logic pa = 1'b0, pd = 1'b0, poe = 1'b0, pdir = 1'b0;
  logic [7:0] pdout = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_astb && !pa) begin
        a_log[astb_cnt % 64] = bus_dout;
        astb_cnt++;
        chk(stab >= int'(T_SETUP), "R2 address setup", stab, T_SETUP);
        if (had_fall) chk(low_run >= int'(T_LOW), "R2 strobe low gap", low_run, T_LOW);
      end
      if (bus_dstb && !pd) begin
        dstb_cnt++;
        if (bus_dir) rd_idx++;
        else begin
          d_log[(dstb_cnt - 1) % 64] = bus_dout;
          chk(stab >= int'(T_SETUP), "R4 data setup", stab, T_SETUP);
        end
        if (had_fall) chk(low_run >= int'(T_LOW), "R4 strobe low gap", low_run, T_LOW);
      end
      if (!bus_astb && pa) chk(a_hi == int'(T_HIGH), "R2 address strobe width", a_hi, T_HIGH);
      if (!bus_dstb && pd) chk(d_hi == int'(T_HIGH), "R4 data strobe width", d_hi, T_HIGH);
      if (pdir && !bus_dir) chk(!poe && !bus_oe, "R6 direction release", poe, 0);
      if ((!bus_astb && pa) || (!bus_dstb && pd)) begin
        had_fall = 1'b1;
        low_run = 1;
      end else if (!bus_astb && !bus_dstb) low_run++;
      if (!busy) had_fall = 1'b0;
      a_hi = bus_astb ? a_hi + 1 : 0;
      d_hi = bus_dstb ? d_hi + 1 : 0;
      if (bus_oe && poe && bus_dout == pdout) stab++;
      else stab = bus_oe ? 1 : 0;
      pa = bus_astb; pd = bus_dstb; poe = bus_oe; pdir = bus_dir; pdout = bus_dout;
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] addr, input int len,
                         input bit exp_busy);
    int n;
    bit ready_leak;
    @(negedge clk);
    chk(cmd_ready, "R11 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == exp_busy, "R11 busy after accept", busy, exp_busy);
    n = 0;
    ready_leak = 1'b0;
    while (busy && n < 5000) begin
      if (cmd_ready) ready_leak = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!ready_leak, "R11 ready low while busy", ready_leak, 0);
    chk(n < 5000, "R11 sequence completes", n, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!bus_oe && !bus_dir, "R1 bus released", {bus_oe, bus_dir}, 0);
    chk(!bus_astb && !bus_dstb, "R1 strobes low", {bus_astb, bus_dstb}, 0);
    chk(!busy && cmd_ready, "R1 idle flags", {busy, cmd_ready}, 1);
    chk(!raw_active && !rd_valid && !wr_ready, "R1 stream and raw", {raw_active, rd_valid, wr_ready}, 0);
  endtask

  task automatic t_select();
    int a0 = astb_cnt, d0 = dstb_cnt;
    run_cmd(3'd0, 8'h5C, 0, 1'b1);
    chk(astb_cnt - a0 == 1, "R3 one address strobe", astb_cnt - a0, 1);
    chk(a_log[a0 % 64] == 8'h5C, "R3 address byte", a_log[a0 % 64], 8'h5C);
    chk(dstb_cnt == d0, "R3 no data strobe", dstb_cnt - d0, 0);
  endtask

  task automatic t_write(input logic [7:0] addr, input int n);
    int a0 = astb_cnt, d0 = dstb_cnt, w0 = wr_idx;
    run_cmd(3'd1, addr, n, 1'b1);
    chk(a_log[a0 % 64] == addr, "R2 write address byte", a_log[a0 % 64], addr);
    chk(dstb_cnt - d0 == n, "R4 data strobe count", dstb_cnt - d0, n);
    chk(wr_idx - w0 == n, "R4 stream bytes taken", wr_idx - w0, n);
    for (int k = 0; k < n; k++)
      chk(d_log[(d0 + k) % 64] == wpat(w0 + k), "R4 write byte order",
          d_log[(d0 + k) % 64], wpat(w0 + k));
  endtask

  task automatic t_read(input logic [7:0] addr, input int n, input bit use_stall);
    int d0 = dstb_cnt, r0 = rd_idx, x0 = rx_n;
    stall = use_stall;
    run_cmd(3'd2, addr, n, 1'b1);
    stall = 1'b0;
    chk(rx_n - x0 == n, "R5 bytes delivered", rx_n - x0, n);
    chk(dstb_cnt - d0 == n, "R5 one strobe per byte", dstb_cnt - d0, n);
    for (int k = 0; k < n; k++)
      chk(rx_log[(x0 + k) % 64] == rpat(r0 + k), "R5 R12 read byte order",
          rx_log[(x0 + k) % 64], rpat(r0 + k));
    chk(!bus_dir && !bus_oe, "R6 released after read", {bus_dir, bus_oe}, 0);
  endtask

  task automatic t_zero_len();
    int a0 = astb_cnt, d0 = dstb_cnt, w0 = wr_idx, x0 = rx_n;
    run_cmd(3'd1, 8'h22, 0, 1'b1);
    run_cmd(3'd2, 8'h23, 0, 1'b1);
    chk(astb_cnt - a0 == 2, "R7 address only", astb_cnt - a0, 2);
    chk(dstb_cnt == d0, "R7 no data strobe", dstb_cnt - d0, 0);
    chk(wr_idx == w0 && rx_n == x0, "R7 streams untouched", (wr_idx - w0) + (rx_n - x0), 0);
  endtask

  task automatic t_raw();
    int a0, d0, w0;
    a0 = astb_cnt;
    run_cmd(3'd3, 8'h77, 0, 1'b1);
    chk(raw_active, "R8 raw entered by op", raw_active, 1);
    chk(a_log[a0 % 64] == 8'h00, "R8 raw address byte", a_log[a0 % 64], 0);
    a0 = astb_cnt;
    run_cmd(3'd0, 8'h31, 0, 1'b0);
    chk(astb_cnt == a0 && raw_active, "R9 command dropped in raw", astb_cnt - a0, 0);
    run_cmd(3'd4, 8'h55, 0, 1'b1);
    chk(astb_cnt - a0 == 1, "R9 exit pulse", astb_cnt - a0, 1);
    chk(!raw_active, "R9 raw cleared", raw_active, 0);
    a0 = astb_cnt;
    run_cmd(3'd4, 8'h55, 0, 1'b0);
    chk(astb_cnt == a0 && !raw_active, "R10 exit ignored when not raw", astb_cnt - a0, 0);
    a0 = astb_cnt; d0 = dstb_cnt; w0 = wr_idx;
    run_cmd(3'd1, 8'h00, 2, 1'b1);
    chk(raw_active, "R8 raw entered by address zero", raw_active, 1);
    chk(astb_cnt - a0 == 1 && a_log[a0 % 64] == 8'h00, "R8 single zero strobe", astb_cnt - a0, 1);
    chk(dstb_cnt == d0 && wr_idx == w0, "R8 no data phase", dstb_cnt - d0, 0);
    run_cmd(3'd4, 8'h00, 0, 1'b1);
    chk(!raw_active, "R9 raw cleared again", raw_active, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wr_valid = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_write(8'h41, 3);
    t_read(8'h84, 4, 1'b0);
    t_read(8'h85, 3, 1'b1);
    t_write(8'h12, 1);
    t_zero_len();
    t_raw();
    t_select();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule